// File: doc/BRIEF.md
# Matrix Keypad Scanner with Key Snapshot FIFO

This block scans a key matrix of up to 16 rows and 8 columns. It drives one row at a time and reads the column lines back. A key is accepted only when its column line stays high for the whole time its row is driven, which rejects contact bounce. When a full scan ends, the accepted keys are packed into byte entries and replace the previous snapshot. Software reads the entries, a key count and two sticky status bits through a small word-addressed register port.

A scan starts with a fixed lead-in during which no row is driven. Each row is then driven for a base time plus a programmable debounce extension. Scans repeat back to back for as long as the block is enabled. An interrupt line reports when the snapshot holds at least a programmed number of keys. It can also report when any key outside a per-key wake mask was seen.

Top module: `keypad_scanner`

## Requirements
- R1: The control word at byte offset 0x00 holds the scan enable in bit 0, the wake interrupt enable in bit 1, the count interrupt enable in bit 3, a 10-bit debounce extension in bits 13:4 (largest value 0x3FF) and a 4-bit count threshold in bits 17:14. All other bits read as zero.
- R2: After the scan enable is set, no row is driven for 5 cycles. Rows 0 to 15 are then driven one at a time in ascending order, each for 16 cycles plus the debounce extension. The lead-in and the row sequence repeat. Clearing the enable releases every row on the next cycle.
- R3: A key is accepted only if its column input is high in every cycle that its row is driven.
- R4: One cycle after the last row of a scan ends, the accepted keys replace the snapshot in row-major order (rows ascending, and columns ascending within a row). An entry byte has bit 7 set for a valid key, the row in bits 6:3 and the column in bits 2:0. Unused entries read as 0x00.
- R5: The snapshot holds at most 8 entries. Keys beyond the first 8 in row-major order are dropped, and the count saturates at 8.
- R6: Offset 0x30 returns entries 0 to 3 and offset 0x34 returns entries 4 to 7, with the lowest entry in bits 7:0.
- R7: Offset 0x04 returns the wake status in bit 0, the count status in bit 2 and the snapshot count in bits 7:4. Writing a 1 to a status bit clears it.
- R8: The count status is set in every cycle in which the count is nonzero and at least the threshold. A clear written while that condition holds has no effect.
- R9: The mask word for row r sits at offset 0x38 + 4*r, and its bit c masks the key at column c. The wake status is set when a snapshot is loaded that contains at least one unmasked key.
- R10: The interrupt output is the wake status ANDed with its enable, ORed with the count status ANDed with its enable.
- R11: While the scan enable is clear, the snapshot, the count and both status bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Byte offset of the register accessed |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| colIn | input | 8 | Column sense lines, high when a key in the driven row is closed |
| rowDrive | output | 16 | Row drive lines, at most one high |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the debounce field is not rewritten while a scan is running. They also assume that the threshold does not exceed the snapshot depth. The bench only changes the control word when the scanner is disabled or when the debounce value stays the same. It changes the key pattern at arbitrary points in a scan. It then waits for two full scans before checking a snapshot, so a scan that mixes old and new keys is never the one judged. Bounce is produced by a column that drops out periodically during its row, and the reference model reproduces that column from the same rule.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  // Register byte offsets
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_INT    = 'h04;
  localparam int OFS_ENT_LO = 'h30;
  localparam int OFS_ENT_HI = 'h34;
  localparam int OFS_MASK   = 'h38;

  // Control word bit positions
  localparam int CB_EN     = 0;
  localparam int CB_WAKEIE = 1;
  localparam int CB_CNTIE  = 3;
  localparam int CB_DEB    = 4;
  localparam int CB_THR    = 14;

  // Entry byte layout: valid | row | column
  localparam int ENT_ROW_W        = 4;
  localparam int ENT_COL_W        = 3;
  localparam int ENTRIES_PER_WORD = 4;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_ROW} scanState_t;

  typedef struct packed {
    logic rowStart;
    logic rowEnd;
    logic scanEnd;
  } scanStrobe_t;
endpackage

// File: rtl/kpd_scan_ctrl.sv
module kpd_scan_ctrl
  import kpd_pkg::*;
#(
  parameter int ROWS       = 16,
  parameter int LEAD_CYCLES = 5,
  parameter int ROW_BASE   = 16,
  parameter int DEB_W      = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 scanEn,
  input  logic [DEB_W-1:0]     debCount,
  output logic [ROWS-1:0]      rowDrive,
  output logic [$clog2(ROWS)-1:0] rowIdx,
  output scanStrobe_t          strobe
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int CNT_W = DEB_W + $clog2(ROW_BASE) + 1;

  scanState_t state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] rowLen;
  logic lastCycle;
  logic lastRow;

  assign rowLen    = CNT_W'(ROW_BASE) + CNT_W'(debCount);
  assign lastCycle = (cnt >= rowLen - CNT_W'(1));
  assign lastRow   = (rowIdx == ROW_W'(ROWS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      rowIdx <= '0;
    end else if (!scanEn) begin
      state  <= S_IDLE;
      cnt    <= '0;
      rowIdx <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          state <= S_LEAD;
          cnt   <= '0;
        end
        S_LEAD: begin
          if (cnt == CNT_W'(LEAD_CYCLES - 1)) begin
            state  <= S_ROW;
            cnt    <= '0;
            rowIdx <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: begin
          if (lastCycle) begin
            cnt <= '0;
            if (lastRow) begin
              state  <= S_LEAD;
              rowIdx <= '0;
            end else begin
              rowIdx <= rowIdx + ROW_W'(1);
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      endcase
    end
  end

  assign rowDrive        = (state == S_ROW) ? (ROWS'(1) << rowIdx) : '0;
  assign strobe.rowStart = (state == S_ROW) && (cnt == '0);
  assign strobe.rowEnd   = (state == S_ROW) && lastCycle;
  assign strobe.scanEnd  = (state == S_ROW) && lastCycle && lastRow;

  // R2: never more than one row driven
  p_row_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowDrive));
  // R2: disabling releases all rows on the next cycle
  p_row_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    !scanEn |=> (rowDrive == '0));
  // R2: rows advance in ascending order
  p_row_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (scanEn && strobe.rowEnd && !strobe.scanEnd) |=> (rowDrive == ($past(rowDrive) << 1)));
endmodule

// File: rtl/kpd_key_path.sv
module kpd_key_path
  import kpd_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int COLS   = 8,
  parameter int DEB_W  = 10,
  parameter int THR_W  = 4,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWe,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [31:0]             regWdata,
  output logic [31:0]             regRdata,
  input  logic [COLS-1:0]         colIn,
  input  logic [$clog2(ROWS)-1:0] rowIdx,
  input  scanStrobe_t             strobe,
  output logic                    scanEn,
  output logic [DEB_W-1:0]        debCount,
  output logic                    irq
);
  localparam int SLOTS   = 2 * ENTRIES_PER_WORD;
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int CNT_W   = $clog2(SLOTS + 1);
  localparam int ENT_W   = 1 + ENT_ROW_W + ENT_COL_W;

  logic wakeIe, cntIe;
  logic [THR_W-1:0] thrReg;
  logic [COLS-1:0] maskReg [ROWS];
  logic [COLS-1:0] acc;
  logic [COLS-1:0] matrix [ROWS];
  logic loadQ;
  logic [SLOTS-1:0][ENT_W-1:0] slots, packSlots;
  logic [CNT_W-1:0] count, packCnt;
  logic anyWake;
  logic wakeStat, cntStat;
  logic ctrlHit, intHit, cntCond;
  logic [13:0] unusedWdata;

  assign unusedWdata = regWdata[31:18];
  assign ctrlHit = regWe && (regAddr == ADDR_W'(OFS_CTRL));
  assign intHit  = regWe && (regAddr == ADDR_W'(OFS_INT));

  // Register file writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanEn   <= 1'b0;
      wakeIe   <= 1'b0;
      cntIe    <= 1'b0;
      debCount <= '0;
      thrReg   <= '0;
      for (int r = 0; r < ROWS; r++) maskReg[r] <= '0;
    end else begin
      if (ctrlHit) begin
        scanEn   <= regWdata[CB_EN];
        wakeIe   <= regWdata[CB_WAKEIE];
        cntIe    <= regWdata[CB_CNTIE];
        debCount <= regWdata[CB_DEB +: DEB_W];
        thrReg   <= regWdata[CB_THR +: THR_W];
      end
      for (int r = 0; r < ROWS; r++)
        if (regWe && regAddr == ADDR_W'(OFS_MASK + 4 * r)) maskReg[r] <= regWdata[COLS-1:0];
    end
  end

  // Debounce: a column survives only if high on every cycle of the row
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc   <= '0;
      loadQ <= 1'b0;
      for (int r = 0; r < ROWS; r++) matrix[r] <= '0;
    end else begin
      acc   <= strobe.rowStart ? colIn : (acc & colIn);
      loadQ <= strobe.scanEnd;
      if (strobe.rowEnd) matrix[rowIdx] <= acc & colIn;
    end
  end

  // Row-major packing of the accepted keys
  always_comb begin
    packSlots = '0;
    packCnt   = '0;
    anyWake   = 1'b0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        if (matrix[r][c]) begin
          if (!maskReg[r][c]) anyWake = 1'b1;
          if (packCnt < CNT_W'(SLOTS)) begin
            packSlots[packCnt[SLOT_W-1:0]] = {1'b1, ENT_ROW_W'(r), ENT_COL_W'(c)};
            packCnt = packCnt + CNT_W'(1);
          end
        end
      end
    end
  end

  assign cntCond = (count != '0) && (int'(count) >= int'(thrReg));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slots    <= '0;
      count    <= '0;
      wakeStat <= 1'b0;
      cntStat  <= 1'b0;
    end else begin
      if (loadQ) begin
        slots <= packSlots;
        count <= packCnt;
      end
      wakeStat <= (wakeStat & ~(intHit & regWdata[0])) | (loadQ & anyWake);
      cntStat  <= (cntStat & ~(intHit & regWdata[2])) | cntCond;
    end
  end

  assign irq = (wakeStat & wakeIe) | (cntStat & cntIe);

  // Read mux
  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(OFS_CTRL)) begin
      regRdata[CB_EN]             = scanEn;
      regRdata[CB_WAKEIE]         = wakeIe;
      regRdata[CB_CNTIE]          = cntIe;
      regRdata[CB_DEB +: DEB_W]   = debCount;
      regRdata[CB_THR +: THR_W]   = thrReg;
    end else if (regAddr == ADDR_W'(OFS_INT)) begin
      regRdata[7:4] = 4'(count);
      regRdata[2]   = cntStat;
      regRdata[0]   = wakeStat;
    end else if (regAddr == ADDR_W'(OFS_ENT_LO)) begin
      regRdata = 32'(slots[ENTRIES_PER_WORD-1:0]);
    end else if (regAddr == ADDR_W'(OFS_ENT_HI)) begin
      regRdata = 32'(slots[SLOTS-1:ENTRIES_PER_WORD]);
    end
    for (int r = 0; r < ROWS; r++)
      if (regAddr == ADDR_W'(OFS_MASK + 4 * r)) regRdata = 32'(maskReg[r]);
  end

  // R5: count never exceeds the snapshot depth
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(SLOTS));
  // R4: snapshot count only moves on a load
  p_count_load_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    !loadQ |=> $stable(count));
  // R8: count status only falls after a clear write
  p_cnt_clear_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cntStat) |-> $past(intHit && regWdata[2]));
  // R9: wake status only rises on a load
  p_wake_on_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeStat) |-> $past(loadQ));
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import kpd_pkg::*;
#(
  parameter int ROWS        = 16,
  parameter int COLS        = 8,
  parameter int LEAD_CYCLES = 5,
  parameter int ROW_BASE    = 16,
  parameter int DEB_W       = 10,
  parameter int THR_W       = 4,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [COLS-1:0]   colIn,
  output logic [ROWS-1:0]   rowDrive,
  output logic              irq
);
  logic scanEn;
  logic [DEB_W-1:0] debCount;
  logic [$clog2(ROWS)-1:0] rowIdx;
  scanStrobe_t strobe;

  kpd_scan_ctrl #(
    .ROWS(ROWS), .LEAD_CYCLES(LEAD_CYCLES), .ROW_BASE(ROW_BASE), .DEB_W(DEB_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .debCount(debCount),
    .rowDrive(rowDrive), .rowIdx(rowIdx), .strobe(strobe)
  );

  kpd_key_path #(
    .ROWS(ROWS), .COLS(COLS), .DEB_W(DEB_W), .THR_W(THR_W), .ADDR_W(ADDR_W)
  ) i_path (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .colIn(colIn), .rowIdx(rowIdx), .strobe(strobe),
    .scanEn(scanEn), .debCount(debCount), .irq(irq)
  );
endmodule

// File: tb/test_keypad_scanner.sv
module test_keypad_scanner;
  localparam int ROWS = 16;
  localparam int COLS = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [COLS-1:0] colIn;
  logic [ROWS-1:0] rowDrive;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int tbCycle = 0;
  logic [7:0] keys [ROWS];
  bit glitchOn = 0;

  always #4 clk = ~clk;
  always @(negedge clk) tbCycle <= tbCycle + 1;

  keypad_scanner i_keypad_scanner (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .colIn(colIn), .rowDrive(rowDrive), .irq(irq)
  );

  // Key matrix: row 2 column 1 drops out every fifth cycle when bounce is on
  function automatic logic [7:0] keyLine(int r);
    logic [7:0] v = keys[r];
    if (glitchOn && r == 2 && (tbCycle % 5 == 0)) v[1] = 1'b0;
    return v;
  endfunction

  always_comb begin
    colIn = '0;
    for (int r = 0; r < ROWS; r++) if (rowDrive[r]) colIn = colIn | keyLine(r);
  end

  // Behavioural reference model
  int mState, mCnt, mRow;
  logic [7:0] mAcc;
  logic [7:0] mMat [ROWS];
  logic [7:0] mMask [ROWS];
  logic [7:0] mEnt [8];
  int mCount;
  bit mLoad, mKp, mFs, mEn, mKpIe, mFsIe;
  int mDeb, mThr;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mRow = 0; mAcc = 0; mLoad = 0; mCount = 0;
      mKp = 0; mFs = 0; mEn = 0; mKpIe = 0; mFsIe = 0; mDeb = 0; mThr = 0;
      for (int i = 0; i < ROWS; i++) begin mMat[i] = 0; mMask[i] = 0; end
      for (int i = 0; i < 8; i++) mEnt[i] = 0;
    end else begin
      logic [7:0] col;
      bit rStart, rEnd, sEnd, wake, cond, clrK, clrF;
      int n;
      logic [7:0] nEnt [8];
      col = (mState == 2) ? keyLine(mRow) : 8'h00;
      rStart = (mState == 2) && (mCnt == 0);
      rEnd = (mState == 2) && (mCnt >= 16 + mDeb - 1);
      sEnd = rEnd && (mRow == ROWS - 1);
      cond = (mCount != 0) && (mCount >= mThr);
      clrK = regWe && regAddr == 8'h04 && regWdata[0];
      clrF = regWe && regAddr == 8'h04 && regWdata[2];
      wake = 0; n = 0;
      for (int i = 0; i < 8; i++) nEnt[i] = 0;
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          if (mMat[r][c]) begin
            if (!mMask[r][c]) wake = 1;
            if (n < 8) begin nEnt[n] = {1'b1, 4'(r), 3'(c)}; n++; end
          end
      mKp = (mKp && !clrK) || (mLoad && wake);
      mFs = (mFs && !clrF) || cond;
      if (mLoad) begin
        mCount = n;
        for (int i = 0; i < 8; i++) mEnt[i] = nEnt[i];
      end
      mLoad = sEnd;
      if (rEnd) mMat[mRow] = mAcc & col;
      mAcc = rStart ? col : (mAcc & col);
      if (!mEn) begin
        mState = 0; mCnt = 0; mRow = 0;
      end else if (mState == 0) begin
        mState = 1; mCnt = 0;
      end else if (mState == 1) begin
        if (mCnt == 4) begin mState = 2; mCnt = 0; mRow = 0; end
        else mCnt++;
      end else begin
        if (rEnd) begin
          mCnt = 0;
          if (mRow == ROWS - 1) begin mState = 1; mRow = 0; end
          else mRow++;
        end else mCnt++;
      end
      if (regWe && regAddr == 8'h00) begin
        mEn = regWdata[0]; mKpIe = regWdata[1]; mFsIe = regWdata[3];
        mDeb = int'(regWdata[13:4]); mThr = int'(regWdata[17:14]);
      end
      for (int r = 0; r < ROWS; r++)
        if (regWe && regAddr == 8'(8'h38 + 4 * r)) mMask[r] = regWdata[7:0];
    end
  end

  function automatic logic [31:0] expRd(logic [7:0] a);
    logic [31:0] v = '0;
    if (a == 8'h00) v = {14'd0, 4'(mThr), 10'(mDeb), mFsIe, 1'b0, mKpIe, mEn};
    else if (a == 8'h04) v = {24'd0, 4'(mCount), 1'b0, mFs, 1'b0, mKp};
    else if (a == 8'h30) v = {mEnt[3], mEnt[2], mEnt[1], mEnt[0]};
    else if (a == 8'h34) v = {mEnt[7], mEnt[6], mEnt[5], mEnt[4]};
    for (int r = 0; r < ROWS; r++) if (a == 8'(8'h38 + 4 * r)) v = {24'd0, mMask[r]};
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always begin
    @(negedge clk);
    #2;
    if (rstN && !done) begin
      string tag;
      chk("R2 rowDrive", 32'(rowDrive), 32'(mState == 2 ? (16'd1 << mRow) : 16'd0));
      chk("R10 irq", 32'(irq), 32'((mKp && mKpIe) || (mFs && mFsIe)));
      tag = (regAddr == 8'h00) ? "R1 read" : (regAddr == 8'h04) ? "R7 read" :
            (regAddr >= 8'h30 && regAddr < 8'h38) ? "R6 read" : "R9 read";
      chk(tag, regRdata, expRd(regAddr));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    regAddr = a;
    #2;
    chk(req, regRdata, exp);
  endtask

  task automatic scanWait();
    do @(negedge clk); while (!rowDrive[ROWS-1]);
    do @(negedge clk); while (rowDrive[ROWS-1]);
    repeat (3) @(negedge clk);
  endtask

  task automatic setKeys(logic [7:0] k [ROWS]);
    @(negedge clk);
    for (int r = 0; r < ROWS; r++) keys[r] = k[r];
  endtask

  initial begin
    logic [7:0] k [ROWS];
    int n;
    for (int r = 0; r < ROWS; r++) begin keys[r] = 0; k[r] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // Reset state
    rd(8'h00, 32'h0, "R1 reset ctrl");
    rd(8'h04, 32'h0, "R7 reset status");
    rd(8'h30, 32'h0, "R4 reset entries");
    chk("R2 reset rows", 32'(rowDrive), 32'h0);
    chk("R10 reset irq", 32'(irq), 32'h0);
    // R1: undefined bits ignored
    wr(8'h00, 32'hFFFC_0004 | 32'h0000_402B);
    rd(8'h00, 32'h0000_402B, "R1 ctrl readback");
    // R2: row length 16+2 and lead-in 5
    do @(negedge clk); while (rowDrive != 16'h0001);
    n = 0;
    while (rowDrive == 16'h0001) begin n++; @(negedge clk); end
    chk("R2 row length", 32'(n), 32'd18);
    do @(negedge clk); while (!rowDrive[ROWS-1]);
    do @(negedge clk); while (rowDrive[ROWS-1]);
    n = 0;
    while (rowDrive == 16'h0) begin n++; @(negedge clk); end
    chk("R2 lead-in", 32'(n), 32'd5);
    scanWait();
    rd(8'h30, 32'h0, "R4 empty snapshot");
    // R4/R6: three keys in row-major order
    k[0] = 8'h04; k[3] = 8'h20; k[15] = 8'h80;
    setKeys(k); scanWait(); scanWait();
    rd(8'h30, 32'h00FF_9D82, "R4 R6 entries low");
    rd(8'h34, 32'h0, "R4 unused entries");
    rd(8'h04, 32'h35, "R7 status and count");
    chk("R10 irq asserted", 32'(irq), 32'h1);
    // R7/R8: clears
    wr(8'h04, 32'h1);
    rd(8'h04, 32'h34, "R7 wake cleared");
    wr(8'h04, 32'h4);
    rd(8'h04, 32'h34, "R8 clear while condition holds");
    scanWait();
    rd(8'h04, 32'h35, "R9 wake set again");
    // R3: bouncing key rejected, clean key kept
    for (int r = 0; r < ROWS; r++) k[r] = 0;
    k[2] = 8'h02; k[5] = 8'h10;
    glitchOn = 1;
    setKeys(k); scanWait(); scanWait();
    rd(8'h30, 32'h0000_00AC, "R3 bounce rejected");
    rd(8'h04, 32'h15, "R3 count one");
    glitchOn = 0;
    // R5: overflow
    for (int r = 0; r < ROWS; r++) k[r] = 0;
    k[0] = 8'h01; k[1] = 8'hFF; k[9] = 8'h08;
    setKeys(k); scanWait(); scanWait();
    rd(8'h30, 32'h8A89_8880, "R5 first four");
    rd(8'h34, 32'h8E8D_8C8B, "R5 last four");
    rd(8'h04, 32'h85, "R5 count saturates");
    // R9: masking
    for (int r = 0; r < ROWS; r++) k[r] = 0;
    k[3] = 8'h20;
    wr(8'h44, 32'h20);
    rd(8'h44, 32'h20, "R9 mask readback");
    setKeys(k); scanWait(); scanWait();
    wr(8'h04, 32'h7);
    scanWait();
    rd(8'h04, 32'h14, "R9 masked key no wake");
    k[4] = 8'h20;
    setKeys(k); scanWait(); scanWait();
    rd(8'h04, 32'h25, "R9 unmasked key wakes");
    // R8: threshold 4
    wr(8'h00, 32'h0001_002B);
    for (int r = 0; r < ROWS; r++) k[r] = 0;
    k[0] = 8'h07;
    setKeys(k); scanWait(); scanWait();
    wr(8'h04, 32'h7);
    scanWait();
    rd(8'h04, 32'h31, "R8 below threshold");
    k[0] = 8'h0F;
    setKeys(k); scanWait(); scanWait();
    rd(8'h04, 32'h45, "R8 at threshold");
    // R10: enable gating
    wr(8'h00, 32'h0001_0021);
    @(negedge clk); #2; chk("R10 gated off", 32'(irq), 32'h0);
    wr(8'h00, 32'h0001_0023);
    @(negedge clk); #2; chk("R10 wake enable", 32'(irq), 32'h1);
    // R11: disable holds state
    wr(8'h00, 32'h0001_0022);
    @(negedge clk); #2; chk("R2 rows released", 32'(rowDrive), 32'h0);
    k[7] = 8'hFF;
    setKeys(k);
    repeat (700) @(negedge clk);
    rd(8'h30, 32'h8382_8180, "R11 entries held");
    rd(8'h04, 32'h45, "R11 status held");
    chk("R11 rows idle", 32'(rowDrive), 32'h0);
    // R1: debounce field width
    wr(8'h00, 32'h0003_FFF0);
    rd(8'h00, 32'h0003_FFF0, "R1 debounce max");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule